// File: doc/BRIEF.md
# Dual-Multiplier Transform Processing Cell

This block is one cell of a systolic transform array. In every cycle it forms a two-term weighted sum, adds it to a partial sum arriving from a neighbouring cell, and registers the result for the next cell. The weights are cosine coefficients read from an internal table that covers a full turn in 64 angle steps. Only one quarter of the wave is stored. Every other coefficient, including any sine value, is derived from that quarter by symmetry. A sine is obtained as the cosine of a quarter turn minus the angle.

A two-bit mode selects how operands reach the two multipliers and the final adder:

- **Paired mode.** Two independent samples are each weighted by their own angle. This serves cosine, sine and Fourier style kernels.
- **Hartley mode.** One sample feeds both multipliers. The second angle is the quarter-turn mirror of the first, so the cell produces x·(cos θ + sin θ).
- **Absolute-difference mode.** The multipliers are bypassed, and the absolute difference of the two samples is accumulated. This serves block-matching sums of absolute differences.

The outgoing sum is clamped to the signed range of the accumulator width instead of wrapping. Coefficients carry a scale of 256. The cell performs no rescaling, so every product adds to the chain in units of 1/256.

Top module: `tc_cell`

## Requirements
- R1: The coefficient for a 6-bit angle index `a` (a full turn in 64 steps, index 0 being 0°) is round(256·cos(2π·a/64)) as a signed 10-bit value. Only 17 quarter-wave magnitudes (0° to 90°) are stored. Indices 32 apart give coefficients of opposite sign.
- R2: With `mode` = 2'b00 or 2'b11 (paired), the next `psum_out` is `psum_in` + `smp_a`·C(`ang_a`) + `smp_b`·C(`ang_b`), where C is the R1 coefficient.
- R3: With `mode` = 2'b01 (Hartley), the next `psum_out` is `psum_in` + `smp_a`·C(`ang_a`) + `smp_a`·C((16 − `ang_a`) mod 64). `smp_b` and `ang_b` have no effect on the result.
- R4: With `mode` = 2'b10 (absolute difference), the next `psum_out` is `psum_in` + |`smp_a` − `smp_b`|. Both angle inputs have no effect, and the result is never below `psum_in` unless clamped.
- R5: `psum_out` is registered. Inputs presented before a rising clock edge appear on `psum_out` just after that edge and not before. A new result is available every cycle.
- R6: A sum above 2^19−1 produces 2^19−1, and a sum below −2^19 produces −2^19 (20-bit accumulator). Sums in range pass unchanged.
- R7: An active-low asynchronous `rst_n` clears `psum_out` to 0 at once, and holds it at 0 while low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00/11 paired, 01 Hartley, 10 absolute difference |
| smp_a | input | DATA_W (8) | First signed sample |
| smp_b | input | DATA_W (8) | Second signed sample, or reference sample in difference mode |
| ang_a | input | 6 | Angle index for the first multiplier |
| ang_b | input | 6 | Angle index for the second multiplier (paired mode only) |
| psum_in | input | ACC_W (20) | Signed partial sum from the neighbouring cell |
| psum_out | output | ACC_W (20) | Registered, clamped signed partial sum |

## Verification
The bench builds the cell with its defaults of 8-bit samples and a 20-bit accumulator. At this size all 4096 angle pairs of paired mode and all 64 Hartley angles can be swept exhaustively against a reference built on real-valued cosines. Extreme samples near the rails make the 19-bit product sums large enough that an incoming partial sum placed near either limit drives both clamps. An asynchronous reset pulse in mid-cycle shows the clear without waiting for a clock edge.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int ANG_W    = 6;
  localparam int COEF_W   = 10;
  localparam int QTR      = 2 ** (ANG_W - 2);
  localparam int HALF     = 2 ** (ANG_W - 1);

  typedef enum logic [1:0] {
    TC_PAIR  = 2'b00,
    TC_HART  = 2'b01,
    TC_ABSD  = 2'b10,
    TC_PAIR2 = 2'b11
  } tc_mode_e;

  // Quarter-wave magnitudes: round(256*cos(i*90deg/16)), i = 0..16
  function automatic logic signed [COEF_W-1:0] quarter_mag(input logic [ANG_W-2:0] i);
    logic signed [COEF_W-1:0] m;
    case (i)
      5'd0:  m = 10'sd256;
      5'd1:  m = 10'sd255;
      5'd2:  m = 10'sd251;
      5'd3:  m = 10'sd245;
      5'd4:  m = 10'sd237;
      5'd5:  m = 10'sd226;
      5'd6:  m = 10'sd213;
      5'd7:  m = 10'sd198;
      5'd8:  m = 10'sd181;
      5'd9:  m = 10'sd162;
      5'd10: m = 10'sd142;
      5'd11: m = 10'sd121;
      5'd12: m = 10'sd98;
      5'd13: m = 10'sd74;
      5'd14: m = 10'sd50;
      5'd15: m = 10'sd25;
      default: m = 10'sd0;
    endcase
    return m;
  endfunction

  // Full-turn cosine from the quarter table by quadrant symmetry
  function automatic logic signed [COEF_W-1:0] cos_coef(input logic [ANG_W-1:0] a);
    logic [1:0]       quad;
    logic [ANG_W-2:0] fwd;
    logic [ANG_W-2:0] rev;
    logic signed [COEF_W-1:0] r;
    quad = a[ANG_W-1 -: 2];
    fwd  = {1'b0, a[ANG_W-3:0]};
    rev  = (ANG_W-1)'(QTR) - fwd;
    case (quad)
      2'd0:    r =  quarter_mag(fwd);
      2'd1:    r = -quarter_mag(rev);
      2'd2:    r = -quarter_mag(fwd);
      default: r =  quarter_mag(rev);
    endcase
    return r;
  endfunction

  // Quarter-turn mirror: sin(theta) = cos(90deg - theta), modulo a full turn
  function automatic logic [ANG_W-1:0] mirror_angle(input logic [ANG_W-1:0] a);
    return ANG_W'(QTR) - a;
  endfunction

endpackage

// File: rtl/tc_coef_rom.sv
module tc_coef_rom
  import tc_pkg::*;
(
  input  logic [ANG_W-1:0]         angle,
  output logic signed [COEF_W-1:0] coef
);

  always_comb coef = cos_coef(angle);

endmodule

// File: rtl/tc_lane.sv
module tc_lane
  import tc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANE   = 0
) (
  input  tc_mode_e                           mode,
  input  logic signed [DATA_W-1:0]           smp_a,
  input  logic signed [DATA_W-1:0]           smp_b,
  input  logic [ANG_W-1:0]                   ang_a,
  input  logic [ANG_W-1:0]                   ang_b,
  output logic signed [COEF_W-1:0]           coef,
  output logic signed [DATA_W+COEF_W-1:0]    prod
);

  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] smp_sel;
  logic [ANG_W-1:0]         ang_sel;
  logic signed [PROD_W-1:0] smp_ext;
  logic signed [PROD_W-1:0] coef_ext;

  generate
    if (LANE == 0) begin : g_direct
      always_comb begin
        smp_sel = smp_a;
        ang_sel = ang_a;
      end
    end else begin : g_routed
      always_comb begin
        if (mode == TC_HART) begin
          smp_sel = smp_a;
          ang_sel = mirror_angle(ang_a);
        end else begin
          smp_sel = smp_b;
          ang_sel = ang_b;
        end
      end
    end
  endgenerate

  tc_coef_rom u_rom (
    .angle (ang_sel),
    .coef  (coef)
  );

  always_comb begin
    smp_ext  = PROD_W'(smp_sel);
    coef_ext = PROD_W'(coef);
    prod     = smp_ext * coef_ext;
  end

endmodule

// File: rtl/tc_sum_stage.sv
module tc_sum_stage
  import tc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  tc_mode_e                          mode,
  input  logic signed [DATA_W-1:0]          smp_a,
  input  logic signed [DATA_W-1:0]          smp_b,
  input  logic signed [DATA_W+COEF_W-1:0]   prod0,
  input  logic signed [DATA_W+COEF_W-1:0]   prod1,
  input  logic signed [ACC_W-1:0]           psum_in,
  output logic signed [ACC_W-1:0]           psum_out
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int TERM_W = PROD_W + 1;
  localparam int EXT_W  = ((ACC_W > TERM_W) ? ACC_W : TERM_W) + 2;
  localparam int DIFF_W = DATA_W + 1;
  localparam logic signed [ACC_W-1:0] ACC_HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_LO = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic [DIFF_W-1:0] abs_gap(input logic signed [DATA_W-1:0] p,
                                                input logic signed [DATA_W-1:0] q);
    logic signed [DIFF_W-1:0] d;
    d = DIFF_W'(p) - DIFF_W'(q);
    return (d < 0) ? DIFF_W'(-d) : DIFF_W'(d);
  endfunction

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [EXT_W-1:0] v);
    if (v > EXT_W'(ACC_HI))      return ACC_HI;
    else if (v < EXT_W'(ACC_LO)) return ACC_LO;
    else                         return ACC_W'(v);
  endfunction

  logic [DIFF_W-1:0]        gap;
  logic signed [EXT_W-1:0]  term;
  logic signed [EXT_W-1:0]  sum_ext;
  logic signed [ACC_W-1:0]  sum_sat;

  always_comb begin
    gap = abs_gap(smp_a, smp_b);
    if (mode == TC_ABSD) term = EXT_W'($signed({1'b0, gap}));
    else                 term = EXT_W'(prod0) + EXT_W'(prod1);
    sum_ext = term + EXT_W'(psum_in);
    sum_sat = clamp(sum_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psum_out <= '0;
    else        psum_out <= sum_sat;
  end

endmodule

// File: rtl/tc_cell.sv
module tc_cell
  import tc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic signed [DATA_W-1:0] smp_a,
  input  logic signed [DATA_W-1:0] smp_b,
  input  logic [5:0]               ang_a,
  input  logic [5:0]               ang_b,
  input  logic signed [ACC_W-1:0]  psum_in,
  output logic signed [ACC_W-1:0]  psum_out
);

  localparam int LANES  = 2;
  localparam int PROD_W = DATA_W + COEF_W;

  tc_mode_e                 mode_e;
  logic signed [COEF_W-1:0] coef_w [LANES];
  logic signed [PROD_W-1:0] prod_w [LANES];

  // Named observation points for the checker
  logic signed [COEF_W-1:0] coef_lane0;
  logic signed [COEF_W-1:0] coef_lane1;

  assign mode_e     = tc_mode_e'(mode);
  assign coef_lane0 = coef_w[0];
  assign coef_lane1 = coef_w[1];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      tc_lane #(.DATA_W(DATA_W), .LANE(g)) u_lane (
        .mode  (mode_e),
        .smp_a (smp_a),
        .smp_b (smp_b),
        .ang_a (ang_a),
        .ang_b (ang_b),
        .coef  (coef_w[g]),
        .prod  (prod_w[g])
      );
    end
  endgenerate

  tc_sum_stage #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_e),
    .smp_a    (smp_a),
    .smp_b    (smp_b),
    .prod0    (prod_w[0]),
    .prod1    (prod_w[1]),
    .psum_in  (psum_in),
    .psum_out (psum_out)
  );

endmodule

// File: rtl/tc_cell_chk.sv
module tc_cell_chk #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               mode,
  input logic signed [DATA_W-1:0] smp_a,
  input logic signed [DATA_W-1:0] smp_b,
  input logic [5:0]               ang_a,
  input logic [5:0]               ang_b,
  input logic signed [ACC_W-1:0]  psum_in,
  input logic signed [ACC_W-1:0]  psum_out,
  input logic signed [9:0]        coef_lane0,
  input logic signed [9:0]        coef_lane1
);

  localparam logic signed [ACC_W-1:0] ACC_HI = {1'b0, {(ACC_W-1){1'b1}}};

  // R7: reset clears the output
  a_r7_reset_clear: assert property (@(posedge clk) !rst_n |=> psum_out == '0);

  // R1: coefficients stay within one unit of scale
  a_r1_coef_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_lane0 <= 10'sd256) && (coef_lane0 >= -10'sd256) &&
    (coef_lane1 <= 10'sd256) && (coef_lane1 >= -10'sd256));

  // R1: half-turn apart gives opposite coefficients
  a_r1_half_turn: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b00) && (6'(ang_b - ang_a) == 6'd32)) |-> (coef_lane1 == -coef_lane0));

  // R2: zero samples pass the partial sum through
  a_r2_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b00 || mode == 2'b11) && smp_a == '0 && smp_b == '0)
      |=> psum_out == $past(psum_in));

  // R3: a zero first sample nulls both Hartley products whatever smp_b holds
  a_r3_hart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && smp_a == '0) |=> psum_out == $past(psum_in));

  // R4: absolute difference never lowers the sum
  a_r4_absd_mono: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> psum_out >= $past(psum_in));

  // R6: top of range holds under a non-negative term
  a_r6_sat_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && psum_in == ACC_HI) |=> psum_out == ACC_HI);

endmodule

bind tc_cell tc_cell_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .smp_a      (smp_a),
  .smp_b      (smp_b),
  .ang_a      (ang_a),
  .ang_b      (ang_b),
  .psum_in    (psum_in),
  .psum_out   (psum_out),
  .coef_lane0 (coef_lane0),
  .coef_lane1 (coef_lane1)
);

// File: tb/sim_tc_cell.sv
`timescale 1ns/1ps
module sim_tc_cell;

  localparam int DATA_W = 8;
  localparam int ACC_W  = 20;
  localparam longint HI = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint LO = -(64'sd1 <<< (ACC_W-1));

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [1:0]               mode = 2'b00;
  logic signed [DATA_W-1:0] smp_a = '0;
  logic signed [DATA_W-1:0] smp_b = '0;
  logic [5:0]               ang_a = '0;
  logic [5:0]               ang_b = '0;
  logic signed [ACC_W-1:0]  psum_in = '0;
  logic signed [ACC_W-1:0]  psum_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tc_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .smp_a(smp_a), .smp_b(smp_b),
    .ang_a(ang_a), .ang_b(ang_b), .psum_in(psum_in), .psum_out(psum_out)
  );

  // Reference coefficient from a real-valued cosine
  function automatic longint ref_cos(input int a);
    real v;
    v = 256.0 * $cos(6.283185307179586 * real'(a % 64) / 64.0);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    else          return -longint'($rtoi(-v + 0.5));
  endfunction

  function automatic longint ref_out(input int md, input int a, input int b,
                                     input int aa, input int ab, input longint ps);
    longint r;
    case (md)
      1:       r = ps + a * ref_cos(aa) + a * ref_cos((80 - aa) % 64);
      2:       r = ps + ((a > b) ? (a - b) : (b - a));
      default: r = ps + a * ref_cos(aa) + b * ref_cos(ab);
    endcase
    if (r > HI) r = HI;
    if (r < LO) r = LO;
    return r;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Drive at the falling edge, observe just after the next rising edge
  task automatic apply(input string tag, input int md, input int a, input int b,
                       input int aa, input int ab, input longint ps);
    @(negedge clk);
    mode = 2'(md); smp_a = DATA_W'(a); smp_b = DATA_W'(b);
    ang_a = 6'(aa); ang_b = 6'(ab); psum_in = ACC_W'(ps);
    @(posedge clk); #1;
    check(tag, longint'(psum_out), ref_out(md, a, b, aa, ab, ps));
  endtask

  task automatic t_reset();
    #1;
    check("R7 reset value", longint'(psum_out), 0);
    repeat (3) @(posedge clk);
    #1;
    check("R7 held in reset", longint'(psum_out), 0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_pair_sweep();
    for (int aa = 0; aa < 64; aa++) begin
      for (int ab = 0; ab < 64; ab++) begin
        apply("R2 paired sweep", (ab % 7 == 3) ? 3 : 0,
              ((aa * 37 + ab * 11) % 256) - 128, ((aa * 13 + ab * 29) % 256) - 128,
              aa, ab, (aa - ab) * 1000);
      end
    end
    apply("R1 coef 90deg is zero", 0, 100, 0, 16, 0, 0);
    apply("R1 coef 180deg is -256", 0, 1, 0, 32, 0, 0);
    apply("R1 coef 45deg is 181", 0, 1, 0, 8, 0, 0);
  endtask

  task automatic t_hart_sweep();
    for (int aa = 0; aa < 64; aa++) begin
      apply("R3 hartley sweep", 1, ((aa * 53) % 256) - 128, (aa * 7) - 100,
            aa, 63 - aa, -aa * 777);
    end
    // R3: smp_b and ang_b must not change the result
    apply("R3 ignores b set1", 1, 77, -128, 5, 0, 123);
    apply("R3 ignores b set2", 1, 77, 127, 5, 40, 123);
  endtask

  task automatic t_absd();
    apply("R4 absd max gap", 2, -128, 127, 9, 33, 0);
    apply("R4 absd reversed", 2, 127, -128, 0, 0, -500);
    apply("R4 absd equal", 2, -3, -3, 17, 55, 4242);
    apply("R4 absd small", 2, 10, 25, 63, 1, -1);
  endtask

  task automatic t_latency();
    apply("R5 setup", 0, 50, 0, 0, 0, 10);
    @(negedge clk);
    mode = 2'b00; smp_a = 8'sd100; smp_b = '0; ang_a = 6'd0; ang_b = 6'd0; psum_in = 20'sd7;
    #1;
    check("R5 output holds before edge", longint'(psum_out), ref_out(0, 50, 0, 0, 0, 10));
    @(posedge clk); #1;
    check("R5 output after edge", longint'(psum_out), ref_out(0, 100, 0, 0, 0, 7));
    // Back-to-back results each cycle
    for (int i = 0; i < 8; i++) begin
      apply("R5 streaming", i % 3, i * 30 - 100, 90 - i * 20, i * 9, i * 5, i * 111);
    end
  endtask

  task automatic t_saturate();
    apply("R6 clamp high", 0, 127, 127, 0, 0, HI - 10);
    apply("R6 clamp low", 0, -128, -128, 0, 0, LO + 10);
    apply("R6 high with absd", 2, -128, 127, 0, 0, HI);
    apply("R6 in range near top", 2, 0, 5, 0, 0, HI - 5);
    apply("R6 low hartley", 1, 127, 0, 40, 0, LO);
  endtask

  task automatic t_reset_mid();
    apply("R7 before async reset", 0, 100, 100, 0, 0, 5000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 async clear", longint'(psum_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply("R7 resume", 0, 1, 1, 0, 0, 2);
  endtask

  initial begin
    t_reset();
    t_pair_sweep();
    t_hart_sweep();
    t_absd();
    t_latency();
    t_saturate();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule